// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block collects every reset request in the chip and turns them into one internal active-high reset for the CPU and its peripherals. The requests are a raw power-on indication, a USB bus reset detection, a watchdog timeout and a low-voltage comparator result. The block also drives an enable for the pulldown on the external reset pin. After power-on it holds the internal reset for a bus-cycle count. A configuration input selects a short or a long count. Any other request that is still active when that count ends extends the reset until the request goes away.

The watchdog and low-voltage requests each take effect only when their own enable option is set. Each of them, on becoming active, pulses the pin pulldown for a single bus cycle. Power-on and USB reset never touch the pin. A four-bit cause register reports the source or sources behind the most recent reset, so software can read it after it restarts.

Top module: `reset_hub`

## Requirements
- R1: With longDelaySel low, after porRaw falls rstOut stays high through the first SHORT_DELAY-1 rising clock edges and is low after edge number SHORT_DELAY (224 by default), provided no other source is active.
- R2: With longDelaySel high, the same count is LONG_DELAY edges (4064 by default).
- R3: If any source is active when the power-on count ends, rstOut stays high and falls after the first edge at which no source is sampled active.
- R4: Power-on alone never raises pinPullEn, either while porRaw is high or during the count that follows.
- R5: A watchdog request with wdogEnable high raises pinPullEn for exactly one cycle, starting at the edge where the request is first sampled active, and rstOut is high from that same edge.
- R6: A low-voltage request with lowVoltEnable high behaves as in R5: a one-cycle pinPullEn pulse together with rstOut.
- R7: A watchdog or low-voltage request whose enable is low has no effect on rstOut, pinPullEn or causeFlags.
- R8: A USB bus reset request sets rstOut high from the edge where it is sampled, keeps it high while it stays active, and never raises pinPullEn.
- R9: Raising porRaw drives rstOut high at once, with no clock edge, and clears pinPullEn. The release of rstOut always happens at a clock edge.
- R10: causeFlags bit 0 marks power-on, bit 1 USB reset, bit 2 watchdog and bit 3 low voltage. While porRaw is high it reads 4'b0001.
- R11: When a reset starts while the chip is running, causeFlags is replaced by the set of sources active at that edge. While reset is held, any source that becomes active is added to the flags already set.
- R12: Raising porRaw again during the power-on count restarts the count, so the full delay is measured from the last fall of porRaw.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| porRaw | input | 1 | Raw power-on indication, active high, asynchronous |
| longDelaySel | input | 1 | Selects the long power-on count; held static |
| usbBusRst | input | 1 | USB bus reset detected |
| wdogTimeout | input | 1 | Watchdog timeout request |
| wdogEnable | input | 1 | Enable option for watchdog reset |
| lowVolt | input | 1 | Low-voltage comparator trip, digital |
| lowVoltEnable | input | 1 | Enable option for low-voltage reset |
| rstOut | output | 1 | Internal reset to CPU and peripherals, active high |
| pinPullEn | output | 1 | Enable for the external reset-pin pulldown |
| causeFlags | output | 4 | Cause of the most recent reset, one bit per source |

## Verification
The bench builds the block with its default parameters: counts of 224 and 4064 cycles, and pin pulses for watchdog and low voltage only. Both counts are short enough to be walked edge by edge, so the release edge of each length is checked exactly. The long count also runs once under directed stimulus. The random phase uses the short count, which lets thousands of cycles of overlapping requests, enable changes and repeated power-on pulses cover the hold, restart and flag-merge paths many times.

// File: rtl/reset_hub_pkg.sv
package reset_hub_pkg;
  localparam int NSRC = 3;
  localparam int SRC_USB = 0;
  localparam int SRC_WDOG = 1;
  localparam int SRC_LVOLT = 2;

  typedef enum logic [1:0] {
    ST_POR  = 2'd0,
    ST_HOLD = 2'd1,
    ST_RUN  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic cntInc;
    logic flagsLoad;
    logic flagsMerge;
  } seqStrobe_t;
endpackage

// File: rtl/reset_hub_dp.sv
module reset_hub_dp
  import reset_hub_pkg::*;
#(
  parameter int SHORT_DELAY = 224,
  parameter int LONG_DELAY = 4064,
  parameter logic [NSRC-1:0] PULSE_MASK = 3'b110
) (
  input  logic            clk,
  input  logic            porRaw,
  input  logic            longDelaySel,
  input  logic [NSRC-1:0] srcReq,
  input  logic [NSRC-1:0] srcEn,
  input  seqStrobe_t      strobe,
  output logic [NSRC-1:0] srcAct,
  output logic            delayDone,
  output logic            pinPullEn,
  output logic [NSRC:0]   causeFlags
);
  localparam int MAX_DELAY = (LONG_DELAY > SHORT_DELAY) ? LONG_DELAY : SHORT_DELAY;
  localparam int CNT_W = $clog2(MAX_DELAY + 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_DELAY - 1);
  localparam logic [CNT_W-1:0] LONG_LAST = CNT_W'(LONG_DELAY - 1);

  logic [CNT_W-1:0] delayCnt;
  logic [NSRC-1:0]  srcRise;

  // Power-on stretch counter, cleared for as long as power-on is present
  always_ff @(posedge clk or posedge porRaw) begin
    if (porRaw) begin
      delayCnt <= '0;
    end else if (strobe.cntInc) begin
      delayCnt <= delayCnt + CNT_W'(1);
    end
  end

  assign delayDone = (delayCnt == (longDelaySel ? LONG_LAST : SHORT_LAST));

  // Per-source gating and optional rising-edge detection for the pin pulse
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign srcAct[i] = srcReq[i] & srcEn[i];
    if (PULSE_MASK[i]) begin : g_pulse
      logic prevQ;
      always_ff @(posedge clk or posedge porRaw) begin
        if (porRaw) begin
          prevQ <= 1'b0;
        end else begin
          prevQ <= srcAct[i];
        end
      end
      assign srcRise[i] = srcAct[i] & ~prevQ;
    end else begin : g_nopulse
      assign srcRise[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or posedge porRaw) begin
    if (porRaw) begin
      pinPullEn <= 1'b0;
    end else begin
      pinPullEn <= |srcRise;
    end
  end

  // Cause register: bit 0 is power-on, upper bits follow the source order
  always_ff @(posedge clk or posedge porRaw) begin
    if (porRaw) begin
      causeFlags <= {{NSRC{1'b0}}, 1'b1};
    end else if (strobe.flagsLoad) begin
      causeFlags <= {srcAct, 1'b0};
    end else if (strobe.flagsMerge) begin
      causeFlags <= causeFlags | {srcAct, 1'b0};
    end
  end
endmodule

// File: rtl/reset_hub_ctrl.sv
module reset_hub_ctrl
  import reset_hub_pkg::*;
(
  input  logic       clk,
  input  logic       porRaw,
  input  logic       delayDone,
  input  logic       anyAct,
  output seqStrobe_t strobe,
  output logic       rstOut
);
  seqState_t state;
  seqState_t stateNext;
  logic      rstNext;

  always_comb begin
    stateNext = state;
    rstNext = 1'b1;
    strobe = '0;
    case (state)
      ST_POR: begin
        strobe.cntInc = 1'b1;
        strobe.flagsMerge = 1'b1;
        if (delayDone) begin
          if (anyAct) begin
            stateNext = ST_HOLD;
          end else begin
            stateNext = ST_RUN;
            rstNext = 1'b0;
          end
        end
      end
      ST_HOLD: begin
        strobe.flagsMerge = 1'b1;
        if (!anyAct) begin
          stateNext = ST_RUN;
          rstNext = 1'b0;
        end
      end
      ST_RUN: begin
        rstNext = 1'b0;
        if (anyAct) begin
          stateNext = ST_HOLD;
          rstNext = 1'b1;
          strobe.flagsLoad = 1'b1;
        end
      end
      default: begin
        stateNext = ST_POR;
      end
    endcase
  end

  // Asynchronous assertion by power-on, release only on a clock edge
  always_ff @(posedge clk or posedge porRaw) begin
    if (porRaw) begin
      state <= ST_POR;
      rstOut <= 1'b1;
    end else begin
      state <= stateNext;
      rstOut <= rstNext;
    end
  end
endmodule

// File: rtl/reset_hub.sv
module reset_hub
  import reset_hub_pkg::*;
#(
  parameter int SHORT_DELAY = 224,
  parameter int LONG_DELAY = 4064,
  parameter logic [NSRC-1:0] PULSE_MASK = 3'b110
) (
  input  logic       clk,
  input  logic       porRaw,
  input  logic       longDelaySel,
  input  logic       usbBusRst,
  input  logic       wdogTimeout,
  input  logic       wdogEnable,
  input  logic       lowVolt,
  input  logic       lowVoltEnable,
  output logic       rstOut,
  output logic       pinPullEn,
  output logic [3:0] causeFlags
);
  logic [NSRC-1:0] srcReq;
  logic [NSRC-1:0] srcEn;
  logic [NSRC-1:0] srcAct;
  logic            delayDone;
  seqStrobe_t      strobe;

  always_comb begin
    srcReq = '0;
    srcEn = '0;
    srcReq[SRC_USB] = usbBusRst;
    srcEn[SRC_USB] = 1'b1;
    srcReq[SRC_WDOG] = wdogTimeout;
    srcEn[SRC_WDOG] = wdogEnable;
    srcReq[SRC_LVOLT] = lowVolt;
    srcEn[SRC_LVOLT] = lowVoltEnable;
  end

  reset_hub_dp #(
    .SHORT_DELAY(SHORT_DELAY),
    .LONG_DELAY(LONG_DELAY),
    .PULSE_MASK(PULSE_MASK)
  ) dpInst (
    .clk(clk),
    .porRaw(porRaw),
    .longDelaySel(longDelaySel),
    .srcReq(srcReq),
    .srcEn(srcEn),
    .strobe(strobe),
    .srcAct(srcAct),
    .delayDone(delayDone),
    .pinPullEn(pinPullEn),
    .causeFlags(causeFlags)
  );

  reset_hub_ctrl ctrlInst (
    .clk(clk),
    .porRaw(porRaw),
    .delayDone(delayDone),
    .anyAct(|srcAct),
    .strobe(strobe),
    .rstOut(rstOut)
  );
endmodule

// File: rtl/reset_hub_chk.sv
module reset_hub_chk (
  input logic       clk,
  input logic       porRaw,
  input logic       usbBusRst,
  input logic       wdogTimeout,
  input logic       wdogEnable,
  input logic       lowVolt,
  input logic       lowVoltEnable,
  input logic       rstOut,
  input logic       pinPullEn,
  input logic [3:0] causeFlags
);
  logic anyReq;
  assign anyReq = usbBusRst | (wdogTimeout & wdogEnable) | (lowVolt & lowVoltEnable);

  AST_SRC_HOLDS_RST: assert property (@(posedge clk) disable iff (porRaw)
    anyReq |=> rstOut); // R8

  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (porRaw)
    $fell(rstOut) |-> !$past(anyReq)); // R3

  AST_PULL_WITH_RST: assert property (@(posedge clk) disable iff (porRaw)
    pinPullEn |-> rstOut); // R5

  AST_POR_NO_PULL: assert property (@(posedge clk) disable iff (porRaw)
    (causeFlags == 4'b0001) |-> !pinPullEn); // R4

  AST_PULL_CAUSE_FLAG: assert property (@(posedge clk) disable iff (porRaw)
    pinPullEn |-> (causeFlags[2] | causeFlags[3])); // R11
endmodule

bind reset_hub reset_hub_chk chkInst (
  .clk(clk),
  .porRaw(porRaw),
  .usbBusRst(usbBusRst),
  .wdogTimeout(wdogTimeout),
  .wdogEnable(wdogEnable),
  .lowVolt(lowVolt),
  .lowVoltEnable(lowVoltEnable),
  .rstOut(rstOut),
  .pinPullEn(pinPullEn),
  .causeFlags(causeFlags)
);

// File: tb/reset_hub_test.sv
`timescale 1ns/1ps
module reset_hub_test;
  localparam int SHORT_D = 224;
  localparam int LONG_D = 4064;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic porRaw, longDelaySel, usbBusRst, wdogTimeout, wdogEnable, lowVolt, lowVoltEnable;
  logic rstOut, pinPullEn;
  logic [3:0] causeFlags;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // Reference model state
  logic mRst, mPull, mDone, mPrevWd, mPrevLv;
  int mCnt;
  logic [3:0] mFlags;

  reset_hub uut (
    .clk(clk), .porRaw(porRaw), .longDelaySel(longDelaySel),
    .usbBusRst(usbBusRst), .wdogTimeout(wdogTimeout), .wdogEnable(wdogEnable),
    .lowVolt(lowVolt), .lowVoltEnable(lowVoltEnable),
    .rstOut(rstOut), .pinPullEn(pinPullEn), .causeFlags(causeFlags)
  );

  function automatic void modelPor();
    mRst = 1'b1; mPull = 1'b0; mDone = 1'b0; mCnt = 0;
    mFlags = 4'b0001; mPrevWd = 1'b0; mPrevLv = 1'b0;
  endfunction

  function automatic void modelEdge();
    logic wdA, lvA;
    logic [3:0] act;
    int lim;
    if (porRaw) begin
      modelPor();
      return;
    end
    wdA = wdogTimeout & wdogEnable;
    lvA = lowVolt & lowVoltEnable;
    act = {lvA, wdA, usbBusRst, 1'b0};
    lim = longDelaySel ? LONG_D : SHORT_D;
    mPull = (wdA & ~mPrevWd) | (lvA & ~mPrevLv);
    mPrevWd = wdA;
    mPrevLv = lvA;
    if (!mDone) begin
      mCnt++;
      if (mCnt == lim) mDone = 1'b1;
    end
    if (!mRst && (act != 4'b0)) mFlags = act;
    else if (mRst) mFlags = mFlags | act;
    mRst = ~mDone | (act != 4'b0);
  endfunction

  task automatic check(string req, string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic stepN(int n);
    repeat (n) begin
      @(posedge clk);
      modelEdge();
      #1;
      check("R1", "rstOut vs model", {3'b0, rstOut}, {3'b0, mRst});
      check("R5", "pinPullEn vs model", {3'b0, pinPullEn}, {3'b0, mPull});
      check("R10", "causeFlags vs model", causeFlags, mFlags);
    end
  endtask

  task automatic setPor(logic v);
    porRaw = v;
    if (v) modelPor();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      $display("FAIL all requirements: watchdog expired, actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit sawPull;
    void'($urandom(32'd20240611));
    porRaw = 1'b1; longDelaySel = 1'b0; usbBusRst = 1'b0; wdogTimeout = 1'b0;
    wdogEnable = 1'b0; lowVolt = 1'b0; lowVoltEnable = 1'b0;
    modelPor();
    #1;
    check("R9", "rstOut at power-on", {3'b0, rstOut}, 4'h1);
    check("R10", "flags at power-on", causeFlags, 4'b0001);
    check("R4", "pull at power-on", {3'b0, pinPullEn}, 4'h0);
    stepN(3);

    // R1 short count, R4 no pull
    setPor(1'b0);
    sawPull = 1'b0;
    for (int i = 0; i < SHORT_D - 1; i++) begin
      stepN(1);
      if (pinPullEn) sawPull = 1'b1;
    end
    check("R1", "rst before short end", {3'b0, rstOut}, 4'h1);
    stepN(1);
    check("R1", "rst after short end", {3'b0, rstOut}, 4'h0);
    check("R4", "pull seen during power-on", {3'b0, sawPull}, 4'h0);

    // R2 long count
    setPor(1'b1); longDelaySel = 1'b1; stepN(2);
    setPor(1'b0);
    stepN(LONG_D - 1);
    check("R2", "rst before long end", {3'b0, rstOut}, 4'h1);
    stepN(1);
    check("R2", "rst after long end", {3'b0, rstOut}, 4'h0);
    longDelaySel = 1'b0;

    // R9 async assertion, then R12 restart
    setPor(1'b1);
    #1;
    check("R9", "rst without clock edge", {3'b0, rstOut}, 4'h1);
    check("R10", "flags on power-on", causeFlags, 4'b0001);
    stepN(1);
    setPor(1'b0); stepN(100);
    setPor(1'b1); stepN(1);
    setPor(1'b0);
    stepN(SHORT_D - 1);
    check("R12", "rst before restarted end", {3'b0, rstOut}, 4'h1);
    stepN(1);
    check("R12", "rst after restarted end", {3'b0, rstOut}, 4'h0);

    // R3 hold by USB at end of count
    setPor(1'b1); usbBusRst = 1'b1; stepN(2);
    setPor(1'b0);
    stepN(SHORT_D);
    check("R3", "rst held by active source", {3'b0, rstOut}, 4'h1);
    stepN(10);
    usbBusRst = 1'b0;
    stepN(1);
    check("R3", "rst released after source idle", {3'b0, rstOut}, 4'h0);
    check("R11", "merged flags after hold", causeFlags, 4'b0011);

    // R5 watchdog pulse
    wdogEnable = 1'b1; wdogTimeout = 1'b1;
    stepN(1);
    check("R5", "wdog pull first cycle", {3'b0, pinPullEn}, 4'h1);
    check("R5", "wdog rst", {3'b0, rstOut}, 4'h1);
    check("R11", "flags replaced by wdog", causeFlags, 4'b0100);
    stepN(1);
    check("R5", "wdog pull second cycle", {3'b0, pinPullEn}, 4'h0);
    wdogTimeout = 1'b0; stepN(2);

    // R6 low-voltage pulse
    lowVoltEnable = 1'b1; lowVolt = 1'b1;
    stepN(1);
    check("R6", "lvolt pull first cycle", {3'b0, pinPullEn}, 4'h1);
    check("R6", "lvolt rst", {3'b0, rstOut}, 4'h1);
    stepN(1);
    check("R6", "lvolt pull second cycle", {3'b0, pinPullEn}, 4'h0);
    usbBusRst = 1'b1; stepN(1);
    check("R11", "usb added while held", causeFlags, 4'b1010);
    usbBusRst = 1'b0; lowVolt = 1'b0; stepN(2);
    check("R3", "released after lvolt", {3'b0, rstOut}, 4'h0);

    // R7 disabled sources
    wdogEnable = 1'b0; lowVoltEnable = 1'b0; wdogTimeout = 1'b1; lowVolt = 1'b1;
    stepN(5);
    check("R7", "disabled rst", {3'b0, rstOut}, 4'h0);
    check("R7", "disabled pull", {3'b0, pinPullEn}, 4'h0);
    check("R7", "disabled flags", causeFlags, 4'b1010);
    wdogTimeout = 1'b0; lowVolt = 1'b0; stepN(1);

    // R8 USB from running state
    usbBusRst = 1'b1;
    stepN(1);
    check("R8", "usb rst", {3'b0, rstOut}, 4'h1);
    check("R8", "usb no pull", {3'b0, pinPullEn}, 4'h0);
    check("R8", "usb flags", causeFlags, 4'b0010);
    stepN(4);
    check("R8", "usb held", {3'b0, rstOut}, 4'h1);
    usbBusRst = 1'b0; stepN(2);

    // Random phase with short count
    for (int i = 0; i < 8000; i++) begin
      if ($urandom_range(0, 29) == 0) usbBusRst = ~usbBusRst;
      if ($urandom_range(0, 19) == 0) wdogTimeout = ~wdogTimeout;
      if ($urandom_range(0, 19) == 0) lowVolt = ~lowVolt;
      if ($urandom_range(0, 59) == 0) wdogEnable = ~wdogEnable;
      if ($urandom_range(0, 59) == 0) lowVoltEnable = ~lowVoltEnable;
      if (porRaw) begin
        if ($urandom_range(0, 2) == 0) setPor(1'b0);
      end else if ($urandom_range(0, 1499) == 0) begin
        setPor(1'b1);
      end
      stepN(1);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule